// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers for a clock generator. It has no register-address pointer. Every write streams from register 0 upward, and every read returns a byte count followed by the whole bank, also from register 0 upward. The two bytes that follow the write address are taken as a command code and a byte count. Both are acknowledged and then thrown away.

SCL and SDA pass through a synchroniser and are oversampled by a fast system clock. SDA is open-drain: the block only ever pulls the line low, through `sda_pull`, and otherwise leaves it released. Each SCL high phase and each SCL low phase must last at least `SYNC_STAGES + 2` system clocks. A start or stop condition seen at any point abandons the current transfer. The register contents are presented in parallel on `cfg_bytes`, with register 0 in the least significant byte.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 0 reads 0x00, registers 1 to 5 read 0xFF, and SDA is released.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged on the ninth clock. Any other address is not acknowledged, and the bytes that follow it are ignored until the next start.
- R3: In a write, the command-code byte and the byte-count byte are acknowledged and change no register.
- R4: Write data bytes land in register 0, register 1 and so on, in arrival order, sent MSB first. Each one is acknowledged.
- R5: A write that ends after k complete data bytes leaves every register at index k or above unchanged. A partly shifted byte writes nothing.
- R6: Data bytes beyond register 5 are acknowledged and change no register.
- R7: A read sends the value 6 first, then registers 0 to 5 MSB first. Any byte requested after register 5 reads as 0xFF.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next start.
- R9: A start condition in the middle of a transfer restarts parsing from the address byte, so the next write data byte lands in register 0.
- R10: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_bytes | output | 48 | Register bank, register 0 in bits 7:0 |

## Verification
Three properties are checked on every cycle:
- SDA is released whenever the engine is idle and after any start or stop.
- The SDA drive changes only while SCL is low.
- The register bank moves only in the cycle after a write strobe, and the write index stays inside the bank.

Some behaviours are visible only through the bench's scenarios:
- which register each data byte reaches, and the arrival order;
- the value and order of the read stream;
- that discarded command and count bytes really leave the bank untouched;
- that an abandoned transfer restarts at register 0.

The bench covers these with a sweep over every data-byte count from zero to past the end of the bank, together with foreign addresses, truncated bytes, mid-transfer starts and an early read NACK.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_state_t;
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [N-1:0] scl_chain;
  logic [N-1:0] sda_chain;
  logic         scl_q;
  logic         sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[N-2:0], scl_in};
      sda_chain <= {sda_chain[N-2:0], sda_in};
      scl_q     <= scl_chain[N-1];
      sda_q     <= sda_chain[N-1];
    end
  end

  assign scl_s     = scl_chain[N-1];
  assign sda_s     = sda_chain[N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgs_reg_bank.sv
module cfgs_reg_bank
  import cfgs_pkg::*;
#(
  parameter int                            NUM_REGS = 6,
  parameter logic [NUM_REGS*BYTE_W-1:0]    REG_INIT = 48'hFFFF_FFFF_FF00,
  localparam int                           REG_AW   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [REG_AW-1:0]            wr_idx,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [REG_AW-1:0]            rd_idx,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [NUM_REGS*BYTE_W-1:0]   regs_flat
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[i] <= REG_INIT[i*BYTE_W +: BYTE_W];
      else if (wr_en && (wr_idx == REG_AW'(i)))
        regs_q[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == REG_AW'(i)) rd_data = regs_q[i];
  end
endmodule

// File: rtl/cfgs_xfer_fsm.sv
module cfgs_xfer_fsm
  import cfgs_pkg::*;
#(
  parameter int          NUM_REGS = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int         REG_AW   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int         CNT_W    = $clog2(NUM_REGS + 3) + 1,
  localparam int         BIT_W    = $clog2(BYTE_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [REG_AW-1:0]  rd_idx,
  output logic               wr_en,
  output logic [REG_AW-1:0]  wr_idx,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               sda_pull,
  output eng_state_t         state
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_REGS = CNT_W'(NUM_REGS);

  logic [BIT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  byte_cnt;
  logic              addr_phase;
  logic              is_read;
  logic              mack_ok;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  logic [CNT_W-1:0]  data_pos;
  logic              data_hit;
  logic [CNT_W-1:0]  rd_pos;
  logic [BYTE_W-1:0] tx_byte;

  // write slot: byte_cnt 0 is command, 1 is count, 2.. are registers
  assign data_pos = byte_cnt - CNT_W'(2);
  assign data_hit = (byte_cnt >= CNT_W'(2)) && (data_pos < CNT_REGS);

  // read slot: byte_cnt 0 is the count, 1.. are registers
  assign rd_pos = byte_cnt - CNT_W'(1);
  assign rd_idx = REG_AW'(rd_pos);

  always_comb begin
    if (byte_cnt == '0)
      tx_byte = BYTE_W'(NUM_REGS);
    else if (rd_pos < CNT_REGS)
      tx_byte = rd_data;
    else
      tx_byte = '1;
  end

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state      <= ST_IDLE;
      sda_pull   <= 1'b0;
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      addr_phase <= 1'b0;
      is_read    <= 1'b0;
      mack_ok    <= 1'b0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else if (start_evt) begin
      state      <= ST_RX;
      sda_pull   <= 1'b0;
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      addr_phase <= 1'b1;
      is_read    <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && (bit_cnt != BIT_W'(BYTE_W))) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + BIT_W'(1);
          end else if (scl_fall && (bit_cnt == BIT_W'(BYTE_W))) begin
            bit_cnt <= '0;
            if (addr_phase) begin
              addr_phase <= 1'b0;
              if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                is_read  <= rx_sh[0];
                sda_pull <= 1'b1;
                state    <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_pull <= 1'b1;
              state    <= ST_ACK;
              if (data_hit) begin
                wr_en   <= 1'b1;
                wr_idx  <= REG_AW'(data_pos);
                wr_data <= rx_sh;
              end
              if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_W'(1);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (is_read) begin
              tx_sh    <= tx_byte;
              sda_pull <= ~tx_byte[BYTE_W-1];
              bit_cnt  <= '0;
              state    <= ST_TX;
              if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_W'(1);
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_MACK;
            end else begin
              tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_pull <= ~tx_sh[BYTE_W-2];
              bit_cnt  <= bit_cnt + BIT_W'(1);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok) begin
              tx_sh    <= tx_byte;
              sda_pull <= ~tx_byte[BYTE_W-1];
              bit_cnt  <= '0;
              state    <= ST_TX;
              if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_W'(1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgs_pkg::*;
#(
  parameter int                          NUM_REGS    = 6,
  parameter int                          SYNC_STAGES = 2,
  parameter logic [6:0]                  DEV_ADDR    = 7'h69,
  parameter logic [NUM_REGS*BYTE_W-1:0]  REG_INIT    = 48'hFFFF_FFFF_FF00,
  localparam int                         REG_AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scl_in,
  input  logic                        sda_in,
  output logic                        sda_pull,
  output logic [NUM_REGS*BYTE_W-1:0]  cfg_bytes
);
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              wr_en;
  logic [REG_AW-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [REG_AW-1:0] rd_idx;
  logic [BYTE_W-1:0] rd_data;
  eng_state_t        eng_state;

  cfgs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  cfgs_xfer_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_pull  (sda_pull),
    .state     (eng_state)
  );

  cfgs_reg_bank #(.NUM_REGS(NUM_REGS), .REG_INIT(REG_INIT)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .regs_flat (cfg_bytes)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
  import cfgs_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int REG_AW   = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        scl_s,
  input logic                        start_evt,
  input logic                        stop_evt,
  input logic                        sda_pull,
  input logic                        wr_en,
  input logic [REG_AW-1:0]           wr_idx,
  input logic [NUM_REGS*BYTE_W-1:0]  cfg_bytes,
  input eng_state_t                  eng_state
);
  assert_idle_release_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_IDLE) |-> !sda_pull);

  assert_start_release_R9: assert property (@(posedge clk) disable iff (rst)
    (start_evt || stop_evt) |=> !sda_pull);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_s);

  assert_idx_in_bank_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_idx) < NUM_REGS));

  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(cfg_bytes));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NUM_REGS(NUM_REGS), .REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_pull  (sda_pull),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .cfg_bytes (cfg_bytes),
  .eng_state (eng_state)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] cfg_bytes;
  wire  sda_line = m_sda & ~sda_pull;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [NREG];

  always #2 clk = ~clk;

  cfg_serial_slave uut (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (m_scl),
    .sda_in    (sda_line),
    .sda_pull  (sda_pull),
    .cfg_bytes (cfg_bytes)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; wq(); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    acked = ~sda_line;
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq();
      v[i] = sda_line;
      wq(); m_scl = 1'b0; wq();
    end
    put_bit(~give_ack);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(cfg_bytes[i*8 +: 8] == model[i], req, cfg_bytes[i*8 +: 8], model[i]);
  endtask

  // write n data bytes; command and count carry junk values
  task automatic do_write(input int n, input int seed);
    bit a;
    bus_start();
    put_byte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
    put_byte(8'hA5 ^ 8'(seed), a); chk(a, "R3 command ack", a, 1);
    put_byte(8'h3C + 8'(seed), a); chk(a, "R3 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(pat(seed, i), a);
      chk(a, (i < NREG) ? "R4 data ack" : "R6 overflow ack", a, 1);
      if (i < NREG) model[i] = pat(seed, i);
    end
    bus_stop();
  endtask

  task automatic do_read(input int n);
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    get_byte(1'b1, v); chk(v == 8'd6, "R7 count byte", v, 6);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, v);
      if (i < NREG) chk(v == model[i], "R7 register byte", v, model[i]);
      else          chk(v == 8'hFF, "R7 past end byte", v, 8'hFF);
    end
    bus_stop();
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      report();
    end
  end

  initial begin
    bit a;
    logic [7:0] v;
    model[0] = 8'h00;
    for (int i = 1; i < NREG; i++) model[i] = 8'hFF;
    wq(5); rst = 1'b0; wq(5);

    // R1: reset contents and released line
    check_bank("R1 reset value");
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);

    // R4/R5/R6/R7: sweep data-byte counts 0..8
    for (int n = 0; n <= NREG + 2; n++) begin
      do_write(n, n + 1);
      check_bank((n <= NREG) ? "R5 partial write" : "R6 overflow write");
      do_read(NREG + 1);
    end

    // R2: foreign addresses are not acked and write nothing
    foreach (model[i]) v = 0;
    bus_start();
    put_byte(8'hD0, a); chk(!a, "R2 foreign address nack", a, 0);
    put_byte(8'h00, a); put_byte(8'h00, a); put_byte(8'h77, a);
    chk(!a, "R2 ignored after nack", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'hA2, a); chk(!a, "R2 foreign address nack", a, 0);
    bus_stop();
    check_bank("R2 bank untouched");

    // R5: partly shifted byte writes nothing
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check_bank("R5 truncated byte");
    chk(sda_pull == 1'b0, "R5 released after stop", sda_pull, 0);

    // R9: mid-transfer start restarts at register 0
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    put_byte(8'h11, a); model[0] = 8'h11;
    bus_start();
    put_byte(8'hD2, a); chk(a, "R9 restart address ack", a, 1);
    put_byte(8'h00, a); put_byte(8'h00, a);
    put_byte(8'h22, a); model[0] = 8'h22;
    bus_stop();
    check_bank("R9 restart lands at register 0");

    // R8: NACK after count byte releases SDA until next start
    bus_start();
    put_byte(8'hD3, a); chk(a, "R8 read address ack", a, 1);
    get_byte(1'b0, v); chk(v == 8'd6, "R8 count before nack", v, 6);
    for (int k = 0; k < 9; k++) begin
      wq(); m_scl = 1'b1; wq();
      chk(sda_line == 1'b1, "R8 line released after nack", sda_line, 1);
      wq(); m_scl = 1'b0; wq();
    end
    bus_stop();
    do_read(NREG);

    done = 1'b1;
    report();
  end
endmodule